// File: doc/BRIEF.md
# Subcarrier Phase Oscillator with Field Realignment

This block is the phase source for a composite video encoder's chroma path. It is a 32-bit phase accumulator clocked by the system clock. While enabled, it adds a programmable increment to the accumulator on every cycle. The increment equals 2^32 times the subcarrier frequency divided by the system clock frequency. The host rounds that quotient to the nearest integer before writing it. For example, a clock of 90 times the subcarrier needs 0x02D82D83. An increment that is off by one in the last bit makes the phase slip steadily across a field.

A field-start strobe, issued by the timing generator inside vertical blanking, returns the accumulator to phase zero. Any beat between the pixel timing and the subcarrier therefore restarts on each field instead of building up. The strobe is also the only moment at which a new increment takes effect, so the phase never jumps partway through a line.

The block outputs the full phase word, a coarse 16-step phase index for a sine lookup, and a single-cycle pulse whenever the accumulator overflows.

The increment write port uses a valid/ready handshake. Ready is held high at all times, so the port never back-pressures the host. A write is accepted in any cycle where valid is high, and a later accepted write replaces a staged value that has not yet been applied.

Top module: `cbn_colorburst_nco`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the phase word is zero, the wrap pulse is low, and the active increment is the DEFAULT_INC parameter (0x04000000 by default).
- R2: In a cycle with enable high and no field strobe, the phase word takes the value (phase + active increment) mod 2^32 at the next clock edge.
- R3: A field strobe forces the phase word to zero at the next clock edge, whether or not enable is high. It takes priority over the increment step in that cycle.
- R4: An accepted write (valid and ready both high) is staged. The active increment changes only at a field strobe, and then takes the staged value as it stood before that cycle. A write in the same cycle as the strobe is applied at the following strobe.
- R5: With enable low and no field strobe, the phase word holds and the wrap pulse is low.
- R6: The wrap pulse is high for exactly one cycle, in the cycle after a step whose sum overflowed 32 bits. It is low after a field strobe and after a hold.
- R7: The phase index equals bits 31:28 of the phase word, giving 16 equal phase steps per subcarrier cycle.
- R8: With increment 0x04000000 (clock equal to 64 times the subcarrier), the phase is exactly zero again after every 64 steps and wraps exactly once per 64 steps. With 0x02D82D83, 90 steps from a field strobe give phase 14 with one wrap.
- R9: The write port's ready output is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Step enable for the accumulator |
| field_start | input | 1 | One-cycle strobe at the field boundary, issued inside blanking |
| inc_valid | input | 1 | Increment write valid |
| inc_data | input | 32 | Host-rounded phase increment |
| inc_ready | output | 1 | Increment write ready, always high |
| phase | output | 32 | Accumulator phase word |
| phase_idx | output | 4 | Top bits of the phase word, a 16-step index |
| wrap | output | 1 | One-cycle overflow pulse |

## Verification
A wrong active increment or a corrupted accumulator shows at the phase port on the very next enabled cycle. The phase word is visible in every cycle, so the deviation is seen before any later field strobe can hide it. An increment applied too early, meaning mid-field, shows as a step size that changes with no strobe before it. An increment applied too late shows as the old step size continuing after a strobe. A missed or extra carry appears on the wrap pin one cycle after the offending step. The exact-ratio runs tie these together: 64 or 90 steps must land on a fixed phase with exactly one wrap.

// File: rtl/cbn_pkg.sv
package cbn_pkg;

  typedef enum logic [1:0] {
    ACC_HOLD  = 2'b00,
    ACC_STEP  = 2'b01,
    ACC_CLEAR = 2'b10
  } acc_op_e;

  function automatic acc_op_e pick_op(input logic field_start, input logic en);
    if (field_start) return ACC_CLEAR;
    if (en)          return ACC_STEP;
    return ACC_HOLD;
  endfunction

endpackage

// File: rtl/cbn_inc_stage.sv
module cbn_inc_stage #(
  parameter int                 PHASE_W     = 32,
  parameter logic [PHASE_W-1:0] DEFAULT_INC = 32'h0400_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [PHASE_W-1:0] wr_data,
  output logic               wr_ready,
  input  logic               apply,
  output logic [PHASE_W-1:0] inc_act
);

  logic [PHASE_W-1:0] staged_q;
  logic [PHASE_W-1:0] active_q;
  logic               accept;

  assign wr_ready = 1'b1;
  assign accept   = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= DEFAULT_INC;
    end else if (accept) begin
      staged_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= DEFAULT_INC;
    end else if (apply) begin
      active_q <= staged_q;
    end
  end

  assign inc_act = active_q;

endmodule

// File: rtl/cbn_phase_acc.sv
module cbn_phase_acc
  import cbn_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  acc_op_e            op,
  input  logic [PHASE_W-1:0] inc,
  output logic [PHASE_W-1:0] acc,
  output logic               carry_pulse
);

  localparam int SUM_W = PHASE_W + 1;

  logic [PHASE_W-1:0] acc_q;
  logic               carry_q;
  logic [SUM_W-1:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      unique case (op)
        ACC_CLEAR: begin
          acc_q   <= '0;
          carry_q <= 1'b0;
        end
        ACC_STEP: begin
          acc_q   <= sum[PHASE_W-1:0];
          carry_q <= sum[SUM_W-1];
        end
        default: begin
          acc_q   <= acc_q;
          carry_q <= 1'b0;
        end
      endcase
    end
  end

  assign acc         = acc_q;
  assign carry_pulse = carry_q;

endmodule

// File: rtl/cbn_phase_quant.sv
module cbn_phase_quant #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 4
) (
  input  logic [PHASE_W-1:0] phase,
  output logic [IDX_W-1:0]   idx
);

  localparam int LSB = PHASE_W - IDX_W;

  generate
    if (IDX_W >= PHASE_W) begin : g_full
      assign idx = IDX_W'(phase);
    end else begin : g_top
      assign idx = phase[PHASE_W-1:LSB];
    end
  endgenerate

endmodule

// File: rtl/cbn_colorburst_nco.sv
module cbn_colorburst_nco
  import cbn_pkg::*;
#(
  parameter int                 PHASE_W     = 32,
  parameter int                 IDX_W       = 4,
  parameter logic [PHASE_W-1:0] DEFAULT_INC = 32'h0400_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               field_start,
  input  logic               inc_valid,
  input  logic [PHASE_W-1:0] inc_data,
  output logic               inc_ready,
  output logic [PHASE_W-1:0] phase,
  output logic [IDX_W-1:0]   phase_idx,
  output logic               wrap
);

  logic [PHASE_W-1:0] inc_act;
  acc_op_e            op;

  assign op = pick_op(field_start, en);

  cbn_inc_stage #(
    .PHASE_W    (PHASE_W),
    .DEFAULT_INC(DEFAULT_INC)
  ) u_inc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(inc_valid),
    .wr_data (inc_data),
    .wr_ready(inc_ready),
    .apply   (field_start),
    .inc_act (inc_act)
  );

  cbn_phase_acc #(
    .PHASE_W(PHASE_W)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .inc        (inc_act),
    .acc        (phase),
    .carry_pulse(wrap)
  );

  cbn_phase_quant #(
    .PHASE_W(PHASE_W),
    .IDX_W  (IDX_W)
  ) u_quant (
    .phase(phase),
    .idx  (phase_idx)
  );

endmodule

// File: rtl/cbn_colorburst_nco_chk.sv
module cbn_colorburst_nco_chk #(
  parameter int PHASE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               field_start,
  input logic               inc_valid,
  input logic               inc_ready,
  input logic [PHASE_W-1:0] phase,
  input logic [PHASE_W-1:0] inc_act,
  input logic               wrap
);

  logic [PHASE_W:0] sum_chk;
  assign sum_chk = {1'b0, phase} + {1'b0, inc_act};

  AST_STEP_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !field_start) |=> (phase == $past(sum_chk[PHASE_W-1:0]))); // R2

  AST_FIELD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (phase == '0 && !wrap)); // R3

  AST_INC_ONLY_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(inc_act)); // R4

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !field_start) |=> ($stable(phase) && !wrap)); // R5

  AST_WRAP_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !field_start) |=> (wrap == $past(sum_chk[PHASE_W]))); // R6

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    inc_valid |-> inc_ready); // R9

endmodule

bind cbn_colorburst_nco cbn_colorburst_nco_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .field_start(field_start),
  .inc_valid  (inc_valid),
  .inc_ready  (inc_ready),
  .phase      (phase),
  .inc_act    (inc_act),
  .wrap       (wrap)
);

// File: tb/cbn_colorburst_nco_test.sv
module cbn_colorburst_nco_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF_INC = 32'h0400_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        field_start = 1'b0;
  logic        inc_valid = 1'b0;
  logic [31:0] inc_data = '0;
  logic        inc_ready;
  logic [31:0] phase;
  logic [3:0]  phase_idx;
  logic        wrap;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  logic [31:0] m_phase;
  logic [31:0] m_active;
  logic [31:0] m_staged;
  logic        m_wrap;
  int          wrap_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbn_colorburst_nco uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .field_start(field_start),
    .inc_valid  (inc_valid),
    .inc_data   (inc_data),
    .inc_ready  (inc_ready),
    .phase      (phase),
    .phase_idx  (phase_idx),
    .wrap       (wrap)
  );

  function automatic logic [32:0] next_sum(input logic [31:0] p, input logic [31:0] i);
    return {1'b0, p} + {1'b0, i};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "phase", phase, m_phase);
    chk("R7", "phase_idx", {28'd0, phase_idx}, {28'd0, m_phase[31:28]});
    chk(req, "wrap", {31'd0, wrap}, {31'd0, m_wrap});
    chk("R9", "inc_ready", {31'd0, inc_ready}, 32'd1);
  endtask

  // one clock: drive at negedge, model the edge, check at next negedge
  task automatic cycle(input logic e, input logic fs, input logic wv, input logic [31:0] wd, input string req);
    logic [32:0] s;
    en = e; field_start = fs; inc_valid = wv; inc_data = wd;
    @(posedge clk);
    if (fs) begin
      m_phase = '0; m_wrap = 1'b0; m_active = m_staged;
    end else if (e) begin
      s = next_sum(m_phase, m_active);
      m_phase = s[31:0]; m_wrap = s[32];
    end else begin
      m_wrap = 1'b0;
    end
    if (wv) m_staged = wd;
    if (m_wrap) wrap_count++;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      misses++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_phase = '0; m_active = DEF_INC; m_staged = DEF_INC; m_wrap = 1'b0; wrap_count = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    // R1: default increment in effect after reset
    cycle(1'b1, 1'b0, 1'b0, '0, "R1");
    chk("R1", "default step", phase, DEF_INC);

    // R8: exact 64x ratio returns to zero every 64 steps
    cycle(1'b0, 1'b1, 1'b0, '0, "R3");
    wrap_count = 0;
    for (int k = 0; k < 128; k++) cycle(1'b1, 1'b0, 1'b0, '0, "R2");
    chk("R8", "phase after 128 steps", phase, 32'd0);
    chk("R8", "wraps in 128 steps", wrap_count, 32'd2);

    // R4: write mid-field does not change step until strobe
    cycle(1'b1, 1'b0, 1'b1, 32'h02D8_2D83, "R4");
    cycle(1'b1, 1'b0, 1'b0, '0, "R4");
    chk("R4", "old step kept", phase, 32'h0800_0000);
    // strobe with a simultaneous write: the 90x value applies, the new write waits
    cycle(1'b1, 1'b1, 1'b1, 32'h1111_1111, "R4");
    wrap_count = 0;
    for (int k = 0; k < 90; k++) cycle(1'b1, 1'b0, 1'b0, '0, "R2");
    chk("R8", "phase after 90 steps", phase, 32'd14);
    chk("R8", "wraps in 90 steps", wrap_count, 32'd1);

    // R5: hold with enable low
    for (int k = 0; k < 5; k++) cycle(1'b0, 1'b0, 1'b0, '0, "R5");
    chk("R5", "held phase", phase, 32'd14);

    // R3: strobe wins without enable, and loads the staged write
    cycle(1'b0, 1'b1, 1'b0, '0, "R3");
    chk("R3", "cleared", phase, 32'd0);
    cycle(1'b1, 1'b0, 1'b0, '0, "R4");
    chk("R4", "staged value applied", phase, 32'h1111_1111);

    // R6: forced overflow
    cycle(1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, "R6");
    cycle(1'b0, 1'b1, 1'b0, '0, "R3");
    cycle(1'b1, 1'b0, 1'b0, '0, "R6");
    chk("R6", "no wrap first step", {31'd0, wrap}, 32'd0);
    cycle(1'b1, 1'b0, 1'b0, '0, "R6");
    chk("R6", "wrap on overflow", {31'd0, wrap}, 32'd1);
    cycle(1'b0, 1'b0, 1'b0, '0, "R6");
    chk("R6", "wrap one cycle", {31'd0, wrap}, 32'd0);

    // random mix of all inputs
    for (int k = 0; k < 3000; k++) begin
      logic e, fs, wv;
      e  = ($urandom % 8) != 0;
      fs = ($urandom % 97) == 0;
      wv = ($urandom % 13) == 0;
      cycle(e, fs, wv, $urandom, "R2");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule